// File: doc/BRIEF.md
# Cartridge Bank-Switch Address Translator

This block sits between a cartridge's ROM chips and two buses: the 8-bit CPU bus and the separate pattern-memory bus of the picture processor. Software writes a register index to a select port and then a value to a data port. These two writes load one of eight internal bank registers. From those registers the block forms two ROM addresses. The program-ROM address is built from the CPU address, and the character-ROM address is built from the pattern-bus address.

Address translation is purely combinational from the registers and the incoming address, so there is no valid/ready handshake and no back-pressure. Each address presented on a bus gets its ROM address in the same cycle. Register writes are sampled on the rising clock edge. Program ROM is `PRG_BANKS` pages of 8 KiB, with a power of two from 2 to 16. Its bank numbers wrap modulo that count.

The mapping is fixed. The low pattern table is split into two 2 KiB windows and the high one into four 1 KiB windows. The upper half of the CPU ROM area always shows the last two program pages.

Top module: `mapper_top`

## Requirements
- R1: A write with `cpu_wr`=1 and `cpu_addr & 16'hE001 == 16'h8000` stores `cpu_data[2:0]` as the select index; data bits 7:3 are ignored.
- R2: A write with `cpu_addr & 16'hE001 == 16'h8001` loads the register named by the select index with `cpu_data[5:0]`; registers 6 and 7 keep only `cpu_data[3:0]` (upper bits read as zero). Any address in $8000-$9FFF decodes by its bit 0 alone.
- R3: Writes with `cpu_addr[15:13] != 3'b100`, or cycles with `cpu_wr`=0, change no register and no index.
- R4: For `ppu_addr[12]`=0, `chr_addr = {reg[ppu_addr[11]][5:1], ppu_addr[10:0]}`; register 0 serves $0000-$07FF, register 1 serves $0800-$0FFF, and the register's bit 0 is unused.
- R5: For `ppu_addr[12]`=1, `chr_addr = {reg[2 + ppu_addr[11:10]], ppu_addr[9:0]}` (registers 2..5 in address order).
- R6: For `cpu_addr[14:13]` = 0 or 1, `prg_addr = {bank, cpu_addr[12:0]}` with bank = register 6 or 7 respectively, ANDed with `PRG_BANKS-1`.
- R7: For `cpu_addr[14:13]` = 2 the bank is `PRG_BANKS-2`; for 3 it is `PRG_BANKS-1`, whatever the registers hold.
- R8: While `rst_n`=0 all eight registers and the index are zero.
- R9: A register write becomes visible on the translated addresses in the first cycle after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern-bus address |
| prg_addr | output | 17 | Program-ROM address |
| chr_addr | output | 16 | Character-ROM address |

## Verification
The bench attacks the decode with mirrored port addresses such as $9FFE and $8FF1, and with writes at $A000-$FFFF. A decoder that looked at more than bit 0 would miss the mirrors, and one that ignored bits 15:13 would corrupt the registers from the upper ROM area. It loads odd values into the 2 KiB registers, where a design that kept bit 0 would shift character data by 1 KiB. It loads high data bits into the program registers. With a reduced `PRG_BANKS` the fixed windows and the wrap are checked, so a design that hardwired the fixed pages to 14 and 15 would point outside the ROM.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int NUM_BANK_REGS = 8;
  localparam int BANK_W        = 6;
  localparam int SEL_W         = $clog2(NUM_BANK_REGS);
  localparam int PRG_REG_W     = 4;
  localparam int PRG_PAGE_W    = 13;
  localparam int PRG_AW        = PRG_PAGE_W + PRG_REG_W;
  localparam int CHR_AW        = 16;
  localparam int PPU_AW        = 13;
  localparam int CPU_AW        = 16;
  localparam int CPU_DW        = 8;
  localparam int REG_PRG_LO    = 6;
  localparam int REG_CHR_2K    = 0;
  localparam int REG_CHR_1K    = 2;

  typedef logic [BANK_W-1:0] bank_t;
  typedef bank_t [NUM_BANK_REGS-1:0] bank_file_t;
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] addr,
  input  logic [CPU_DW-1:0] wdata,
  output bank_file_t        banks,
  output logic [SEL_W-1:0]  sel
);
  logic port_hit, sel_we, data_we;

  assign port_hit = wr_en && (addr[15:13] == 3'b100);
  assign sel_we   = port_hit && !addr[0];
  assign data_we  = port_hit && addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      sel <= '0;
    else if (sel_we) sel <= wdata[SEL_W-1:0];
  end

  for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_bank
    localparam bank_t KEEP = (i >= REG_PRG_LO) ? bank_t'((1 << PRG_REG_W) - 1) : '1;
    bank_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               q <= '0;
      else if (data_we && sel == SEL_W'(i))     q <= wdata[BANK_W-1:0] & KEEP;
    end
    assign banks[i] = q;
  end
endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 16
)(
  input  bank_t             bank_lo,
  input  bank_t             bank_hi,
  input  logic [1:0]        window,
  input  logic [PRG_PAGE_W-1:0] offset,
  output logic [PRG_AW-1:0] prg_addr
);
  localparam logic [PRG_REG_W-1:0] MASK   = PRG_REG_W'(PRG_BANKS - 1);
  localparam logic [PRG_REG_W-1:0] FIX_C0 = PRG_REG_W'(PRG_BANKS - 2);
  localparam logic [PRG_REG_W-1:0] FIX_E0 = PRG_REG_W'(PRG_BANKS - 1);

  logic [PRG_REG_W-1:0] raw;

  always_comb begin
    unique case (window)
      2'd0:    raw = bank_lo[PRG_REG_W-1:0];
      2'd1:    raw = bank_hi[PRG_REG_W-1:0];
      2'd2:    raw = FIX_C0;
      default: raw = FIX_E0;
    endcase
  end

  assign prg_addr = {raw & MASK, offset};
endmodule

// File: rtl/mapper_chr_xlate.sv
module mapper_chr_xlate
  import mapper_pkg::*;
(
  input  bank_file_t        banks,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic [CHR_AW-1:0] chr_addr
);
  logic [SEL_W-1:0] idx_2k, idx_1k;
  bank_t            b2k, b1k;

  assign idx_2k = SEL_W'(REG_CHR_2K) + {2'b00, ppu_addr[11]};
  assign idx_1k = SEL_W'(REG_CHR_1K) + {1'b0, ppu_addr[11:10]};
  assign b2k    = banks[idx_2k];
  assign b1k    = banks[idx_1k];

  always_comb begin
    if (!ppu_addr[12]) chr_addr = {b2k[BANK_W-1:1], ppu_addr[10:0]};
    else               chr_addr = {b1k, ppu_addr[9:0]};
  end
endmodule

// File: rtl/mapper_top.sv
module mapper_top
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic [12:0] ppu_addr,
  output logic [16:0] prg_addr,
  output logic [15:0] chr_addr
);
  bank_file_t       bank_regs;
  logic [SEL_W-1:0] sel_idx;

  mapper_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .addr(cpu_addr),
    .wdata(cpu_data), .banks(bank_regs), .sel(sel_idx)
  );

  mapper_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .bank_lo(bank_regs[REG_PRG_LO]), .bank_hi(bank_regs[REG_PRG_LO+1]),
    .window(cpu_addr[14:13]), .offset(cpu_addr[PRG_PAGE_W-1:0]),
    .prg_addr(prg_addr)
  );

  mapper_chr_xlate u_chr (
    .banks(bank_regs), .ppu_addr(ppu_addr), .chr_addr(chr_addr)
  );
endmodule

// File: rtl/mapper_checks.sv
module mapper_checks
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr,
  input logic [15:0]      cpu_addr,
  input logic [7:0]       cpu_data,
  input logic [12:0]      ppu_addr,
  input logic [16:0]      prg_addr,
  input logic [15:0]      chr_addr,
  input logic [SEL_W-1:0] sel,
  input bank_file_t       banks
);
  logic hit;
  assign hit = cpu_wr && (cpu_addr[15:13] == 3'b100);

  a_r1_select_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cpu_addr[0]) |=> sel == $past(cpu_data[2:0]));

  a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cpu_addr[0]) |=> banks[$past(sel)][3:0] == $past(cpu_data[3:0]));

  a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(banks) && $stable(sel)));

  a_r4_low_offset: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_addr[12] |-> chr_addr[10:0] == ppu_addr[10:0]);

  a_r5_high_offset: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_addr[12] |-> chr_addr[9:0] == ppu_addr[9:0]);

  a_r7_fixed_c000: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'd2) |-> prg_addr[16:13] == 4'(PRG_BANKS - 2));

  a_r7_fixed_e000: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'd3) |-> prg_addr[16:13] == 4'(PRG_BANKS - 1));
endmodule

bind mapper_top mapper_checks #(.PRG_BANKS(PRG_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
  .chr_addr(chr_addr), .sel(sel_idx), .banks(bank_regs)
);

// File: tb/sim_mapper_top.sv
`timescale 1ns/1ps
module sim_mapper_top;
  localparam int PB = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_wr = 0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [7:0]  cpu_data = 0;
  logic [12:0] ppu_addr = 0;
  logic [16:0] prg_addr;
  logic [15:0] chr_addr;

  int checks = 0;
  int errors = 0;
  int mb[8];
  int msel = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mapper_top #(.PRG_BANKS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .chr_addr(chr_addr)
  );

  function automatic int exp_prg(int a);
    int w = (a >> 13) & 3;
    int b = (w == 0) ? mb[6] : (w == 1) ? mb[7] : (w == 2) ? PB - 2 : PB - 1;
    return ((b & (PB - 1)) * 8192) + (a & 8191);
  endfunction

  function automatic int exp_chr(int p);
    if (p < 4096) return ((mb[(p >> 11) & 1] >> 1) * 2048) + (p & 2047);
    return (mb[2 + ((p >> 10) & 3)] * 1024) + (p & 1023);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst_n && cpu_wr && (cpu_addr & 16'hE000) == 16'h8000) begin
      if (cpu_addr[0]) mb[msel] = (msel >= 6) ? (cpu_data & 15) : (cpu_data & 63);
      else             msel = cpu_data & 7;
    end
  endtask

  // drive at negedge, compare 1 ns later, update model at the next posedge
  task automatic cyc(bit wr, int a, int d, int p, string ptag = "", string ctag = "");
    @(negedge clk);
    cpu_wr = wr; cpu_addr = 16'(a); cpu_data = 8'(d); ppu_addr = 13'(p);
    #1;
    chk(ptag != "" ? ptag : (((a >> 13) & 3) < 2 ? "R6" : "R7"), int'(prg_addr), exp_prg(a));
    chk(ctag != "" ? ctag : (p < 4096 ? "R4" : "R5"), int'(chr_addr), exp_chr(p));
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mb[i] = 0;
    // R8: reset state, even with write strobe active
    cyc(1, 16'h8001, 8'h3F, 13'h1C00, "R8", "R8");
    cyc(0, 16'h8000, 0, 13'h0800, "R8", "R8");
    @(negedge clk); rst_n = 1;
    // R1: index with high data bits set, R2: load via mirror addresses
    cyc(1, 16'h9FFE, 8'hFA, 13'h0000);          // select 2
    cyc(1, 16'h8FF1, 8'hEA, 13'h0000);          // reg2 = 0x2A
    cyc(0, 16'h0000, 0, 13'h1000, "", "R9");    // visible next cycle
    cyc(1, 16'h8000, 8'h00, 13'h0000);          // select 0
    cyc(1, 16'h8001, 8'h2B, 13'h0000);          // odd value: bit0 dropped
    cyc(0, 16'h8000, 0, 13'h0123, "", "R4");
    cyc(1, 16'h8000, 8'h06, 13'h0000);          // select 6
    cyc(1, 16'h9001, 8'h3D, 13'h0000);          // PRG keeps 4 bits, wraps mod PB
    cyc(0, 16'h8456, 0, 0, "R2", "");
    cyc(1, 16'h8000, 8'h07, 0);
    cyc(1, 16'h8001, 8'h03, 0);
    cyc(0, 16'hA010, 0, 0, "R6", "");
    // R3: writes in $A000-$FFFF change nothing
    cyc(1, 16'hA001, 8'h11, 13'h1000, "R3", "R3");
    cyc(1, 16'hE001, 8'h22, 13'h1000, "R3", "R3");
    cyc(1, 16'h0001, 8'h33, 13'h1000, "R3", "R3");
    cyc(0, 16'hC000, 0, 13'h1000, "R7", "R3");
    cyc(0, 16'hFFFF, 0, 13'h1FFF, "R7", "");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int a = $urandom & 16'hFFFF;
      int r = $urandom % 4;
      if (r == 0) a = 16'h8000 | (a & 16'h1FFF);
      cyc(($urandom % 3) != 0, a, $urandom & 255, $urandom & 13'h1FFF);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule